// File: doc/BRIEF.md
# Instruction-Triggered Low-Power Mode Controller

This block is the power-mode controller of a small microcontroller core. The core normally runs with every clock enabled. When it executes its stop instruction, it raises a one-cycle strobe. The controller then moves into one of three low-power modes: wait, doze or stop. A mode-select register, written by software beforehand, chooses which of the three it enters.

Each mode drives its own pattern of clock enables:

- **Wait** gates off the CPU clock and the memory clock. All peripherals keep running.
- **Doze** also gates off the CPU and memory clocks. It additionally gates off those peripherals that a doze mask register names. The mask value is captured at the moment of entry.
- **Stop** gates off every clock.

Wake-up works as follows:

- In wait or doze, any interrupt line brings the core back to run.
- In stop, only an external interrupt does.
- The clock source is assumed to keep running, so the enables return on the next cycle with no recovery delay.

Independently of the mode, a peripheral enable register switches each gated peripheral's clock on or off.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode output reads run (mode encoding: 00 run, 01 wait, 10 doze, 11 stop). CPU, memory and always-on enables are 1 and all peripheral enables are 1. The mode-select register resets to 00, the doze mask to all zeros and the peripheral enable register to all ones.
- R2: A stop strobe in run with mode-select value 00 or 11 enters wait in the next cycle. In wait, CPU and memory enables are 0, the always-on enable is 1, and the peripheral enables equal the peripheral enable register.
- R3: A stop strobe in run with mode-select value 01 enters doze in the next cycle. In doze, CPU and memory enables are 0 and the always-on enable is 1. The peripheral enables equal the enable register AND NOT the doze mask captured at entry.
- R4: A stop strobe in run with mode-select value 10 enters stop in the next cycle. In stop, every enable output is 0.
- R5: In wait or doze, any set bit of the internal or external interrupt inputs returns the mode to run on the next cycle, with all run enables restored in that same cycle.
- R6: In stop, the internal interrupt inputs have no effect. Only a set bit of the external interrupt inputs returns the mode to run on the next cycle.
- R7: Writes to the mode-select register or the doze mask never change the current mode or its gating. A write in the same cycle as a stop strobe does not affect that entry, and only a later stop strobe uses it.
- R8: A write to the peripheral enable register changes the peripheral enables from the next cycle on, in run, wait and doze. Register addresses are 0 mode select (data bits 1:0), 1 doze mask, 2 peripheral enable, and 3 is ignored.
- R9: A stop strobe arriving while the mode is not run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | NPER | Register write data |
| stop_insn | input | 1 | One-cycle strobe from the executed stop instruction |
| irq_int | input | NINT | Internal (peripheral) interrupt lines |
| irq_ext | input | NEXT | External interrupt lines |
| cpu_clk_en | output | 1 | CPU clock enable |
| mem_clk_en | output | 1 | Memory clock enable |
| per_clk_en | output | NPER | Clock enables of the gated peripherals |
| aon_clk_en | output | 1 | Clock enable of the always-on peripherals |
| mode_o | output | 2 | Current mode |

## Verification
Each mode-select value is tried with stop strobes followed by idle cycles and then wake-ups. This separates the four decodings, including the reserved code falling back to wait.

Wake-up is tried separately with internal-only and external-only interrupts in each mode. This tells the any-interrupt rule of wait and doze apart from the external-only rule of stop.

Register writes are placed during a sleep, in the same cycle as the strobe, and to the unused address. This distinguishes a snapshot taken at entry from a live register path. Enable-register writes during doze show the mask and the enable combining bit by bit.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_DOZE = 2'b10,
        MODE_STOP = 2'b11
    } lp_mode_e;

    localparam logic [1:0] ADDR_SEL  = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_EN   = 2'd2;

    // Mode-select code to target mode; the reserved code falls back to wait
    function automatic lp_mode_e sel_to_mode(input logic [1:0] code);
        case (code)
            2'b01:   return MODE_DOZE;
            2'b10:   return MODE_STOP;
            default: return MODE_WAIT;
        endcase
    endfunction
endpackage

// File: rtl/lpm_regs.sv
module lpm_regs #(
    parameter int NPER = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [1:0]      addr,
    input  logic [NPER-1:0] wdata,
    output logic [1:0]      sel,
    output logic [NPER-1:0] dmask,
    output logic [NPER-1:0] pen
);
    import lpm_pkg::*;

    typedef struct packed {
        logic [1:0]      sel;
        logic [NPER-1:0] dmask;
        logic [NPER-1:0] pen;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                ADDR_SEL:  r_d.sel   = wdata[1:0];
                ADDR_MASK: r_d.dmask = wdata;
                ADDR_EN:   r_d.pen   = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.sel   <= 2'b00;
            r_q.dmask <= '0;
            r_q.pen   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel   = r_q.sel;
    assign dmask = r_q.dmask;
    assign pen   = r_q.pen;
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm #(
    parameter int NPER = 8,
    parameter int NINT = 8,
    parameter int NEXT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_insn,
    input  logic [NINT-1:0]   irq_int,
    input  logic [NEXT-1:0]   irq_ext,
    input  logic [1:0]        sel,
    input  logic [NPER-1:0]   dmask,
    output lpm_pkg::lp_mode_e mode,
    output logic [NPER-1:0]   snap_mask
);
    import lpm_pkg::*;

    typedef struct packed {
        lp_mode_e        mode;
        logic [NPER-1:0] snap;
    } st_t;

    st_t s_d, s_q;
    logic any_int, any_ext;

    assign any_int = |irq_int;
    assign any_ext = |irq_ext;

    always_comb begin
        s_d = s_q;
        case (s_q.mode)
            MODE_RUN: begin
                if (stop_insn) begin
                    s_d.mode = sel_to_mode(sel);
                    s_d.snap = dmask;
                end
            end
            MODE_WAIT, MODE_DOZE: begin
                if (any_int || any_ext) s_d.mode = MODE_RUN;
            end
            MODE_STOP: begin
                if (any_ext) s_d.mode = MODE_RUN;
            end
            default: s_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode <= MODE_RUN;
            s_q.snap <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode      = s_q.mode;
    assign snap_mask = s_q.snap;
endmodule

// File: rtl/lpm_gate.sv
module lpm_gate #(
    parameter int NPER = 8
) (
    input  lpm_pkg::lp_mode_e mode,
    input  logic [NPER-1:0]   snap_mask,
    input  logic [NPER-1:0]   pen,
    output logic              cpu_en,
    output logic              mem_en,
    output logic              aon_en,
    output logic [NPER-1:0]   per_en
);
    import lpm_pkg::*;

    logic core_on, dozing, halted;

    assign core_on = (mode == MODE_RUN);
    assign dozing  = (mode == MODE_DOZE);
    assign halted  = (mode == MODE_STOP);

    assign cpu_en = core_on;
    assign mem_en = core_on;
    assign aon_en = !halted;

    for (genvar i = 0; i < NPER; i++) begin : g_per
        assign per_en[i] = pen[i] && !halted && !(dozing && snap_mask[i]);
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
    parameter int NPER = 8,
    parameter int NINT = 8,
    parameter int NEXT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_addr,
    input  logic [NPER-1:0] cfg_wdata,
    input  logic            stop_insn,
    input  logic [NINT-1:0] irq_int,
    input  logic [NEXT-1:0] irq_ext,
    output logic            cpu_clk_en,
    output logic            mem_clk_en,
    output logic [NPER-1:0] per_clk_en,
    output logic            aon_clk_en,
    output logic [1:0]      mode_o
);
    import lpm_pkg::*;

    logic [1:0]      sel;
    logic [NPER-1:0] dmask, pen, snap_mask;
    lp_mode_e        mode;

    lpm_regs #(.NPER(NPER)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .sel(sel), .dmask(dmask), .pen(pen)
    );

    lpm_fsm #(.NPER(NPER), .NINT(NINT), .NEXT(NEXT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .stop_insn(stop_insn), .irq_int(irq_int),
        .irq_ext(irq_ext), .sel(sel), .dmask(dmask), .mode(mode), .snap_mask(snap_mask)
    );

    lpm_gate #(.NPER(NPER)) u_gate (
        .mode(mode), .snap_mask(snap_mask), .pen(pen),
        .cpu_en(cpu_clk_en), .mem_en(mem_clk_en), .aon_en(aon_clk_en), .per_en(per_clk_en)
    );

    assign mode_o = mode;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
    parameter int NPER = 8,
    parameter int NINT = 8,
    parameter int NEXT = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stop_insn,
    input logic [NINT-1:0] irq_int,
    input logic [NEXT-1:0] irq_ext,
    input logic            cpu_clk_en,
    input logic            mem_clk_en,
    input logic [NPER-1:0] per_clk_en,
    input logic            aon_clk_en,
    input logic [1:0]      mode_o
);
    // R2
    enter_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && stop_insn) |=> (mode_o != 2'b00));

    // R3
    core_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b00) |-> (!cpu_clk_en && !mem_clk_en));

    // R4
    stop_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11) |-> (!cpu_clk_en && !mem_clk_en && !aon_clk_en && per_clk_en == '0));

    // R5
    light_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 2'b01 || mode_o == 2'b10) && (|irq_int || |irq_ext))
        |=> (mode_o == 2'b00 && cpu_clk_en && mem_clk_en && aon_clk_en));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11 && irq_ext == '0) |=> (mode_o == 2'b11));

    // R9
    strobe_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b00 && irq_int == '0 && irq_ext == '0) |=> $stable(mode_o));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NPER(NPER), .NINT(NINT), .NEXT(NEXT)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_insn(stop_insn), .irq_int(irq_int), .irq_ext(irq_ext),
    .cpu_clk_en(cpu_clk_en), .mem_clk_en(mem_clk_en), .per_clk_en(per_clk_en),
    .aon_clk_en(aon_clk_en), .mode_o(mode_o)
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
    localparam int NPER = 8;
    localparam int NINT = 8;
    localparam int NEXT = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_addr = '0;
    logic [NPER-1:0] cfg_wdata = '0;
    logic            stop_insn = 1'b0;
    logic [NINT-1:0] irq_int = '0;
    logic [NEXT-1:0] irq_ext = '0;
    logic            cpu_clk_en, mem_clk_en, aon_clk_en;
    logic [NPER-1:0] per_clk_en;
    logic [1:0]      mode_o;

    always #4 clk = ~clk; // 125 MHz

    lpm_ctrl #(.NPER(NPER), .NINT(NINT), .NEXT(NEXT)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .stop_insn(stop_insn), .irq_int(irq_int), .irq_ext(irq_ext),
        .cpu_clk_en(cpu_clk_en), .mem_clk_en(mem_clk_en), .per_clk_en(per_clk_en),
        .aon_clk_en(aon_clk_en), .mode_o(mode_o)
    );

    // Behavioural reference: mode 0 run, 1 wait, 2 doze, 3 stop
    int              m_mode;
    int              m_sel;
    logic [NPER-1:0] m_mask, m_en, m_snap;
    int              n_cmp = 0;
    int              n_bad = 0;
    string           cur_req = "R1";
    bit              done = 0;

    task automatic model_update();
        int nm;
        if (!rst_n) begin
            m_mode = 0; m_sel = 0; m_mask = '0; m_en = '1; m_snap = '0;
            return;
        end
        nm = m_mode;
        if (m_mode == 0) begin
            if (stop_insn) begin
                nm = (m_sel == 1) ? 2 : (m_sel == 2) ? 3 : 1;
                m_snap = m_mask;
            end
        end else if (m_mode == 3) begin
            if (irq_ext != 0) nm = 0;
        end else if (irq_int != 0 || irq_ext != 0) begin
            nm = 0;
        end
        m_mode = nm;
        if (cfg_we) begin
            if (cfg_addr == 2'd0) m_sel = int'(cfg_wdata[1:0]);
            else if (cfg_addr == 2'd1) m_mask = cfg_wdata;
            else if (cfg_addr == 2'd2) m_en = cfg_wdata;
        end
    endtask

    task automatic compare();
        logic [NPER-1:0] e_per;
        logic e_core, e_aon;
        e_core = (m_mode == 0);
        e_aon  = (m_mode != 3);
        e_per  = (m_mode == 3) ? '0 : (m_mode == 2) ? (m_en & ~m_snap) : m_en;
        n_cmp++;
        if (int'(mode_o) != m_mode || cpu_clk_en != e_core || mem_clk_en != e_core ||
            aon_clk_en != e_aon || per_clk_en != e_per) begin
            n_bad++;
            $display("FAIL %s: got mode=%0d cpu=%b mem=%b aon=%b per=%b, expected mode=%0d cpu=%b mem=%b aon=%b per=%b",
                     cur_req, mode_o, cpu_clk_en, mem_clk_en, aon_clk_en, per_clk_en,
                     m_mode, e_core, e_core, e_aon, e_per);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic clear_in();
        cfg_we = 1'b0; stop_insn = 1'b0; irq_int = '0; irq_ext = '0;
    endtask

    task automatic idle(input int n);
        clear_in();
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [NPER-1:0] d);
        clear_in();
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        clear_in();
    endtask

    task automatic stop_now();
        clear_in();
        stop_insn = 1'b1;
        tick();
        clear_in();
    endtask

    task automatic irq(input logic [NINT-1:0] i, input logic [NEXT-1:0] e);
        clear_in();
        irq_int = i; irq_ext = e;
        tick();
        clear_in();
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_mode = 0; m_sel = 0; m_mask = '0; m_en = '1; m_snap = '0;
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        cur_req = "R1"; idle(3);

        // R2: code 00 -> wait, then wake on internal irq (R5)
        cur_req = "R2"; wr(2'd0, 8'h00); stop_now(); idle(3);
        cur_req = "R5"; irq(8'h10, 4'h0); idle(2);
        // R2: reserved code 11 -> wait, wake on external
        cur_req = "R2"; wr(2'd0, 8'h03); stop_now(); idle(2);
        cur_req = "R5"; irq(8'h00, 4'h2); idle(1);

        // R3: doze with a mask
        cur_req = "R3"; wr(2'd1, 8'hA5); wr(2'd0, 8'h01); stop_now(); idle(3);
        // R7: writes during doze change nothing
        cur_req = "R7"; wr(2'd1, 8'h0F); wr(2'd0, 8'h02); idle(2);
        // R8: enable write during doze applies at once, masked by snapshot
        cur_req = "R8"; wr(2'd2, 8'h3C); idle(2);
        // R9: strobe during doze ignored
        cur_req = "R9"; stop_now(); idle(2);
        cur_req = "R5"; irq(8'h01, 4'h0); idle(1);

        // R4: stop (sel now 10 from the write during doze)
        cur_req = "R4"; stop_now(); idle(3);
        cur_req = "R6"; irq(8'hFF, 4'h0); idle(2);
        cur_req = "R9"; stop_now(); idle(1);
        cur_req = "R6"; irq(8'h00, 4'h8); idle(2);

        // R7: write in the same cycle as the stop strobe uses the old code
        cur_req = "R7"; wr(2'd0, 8'h00);
        clear_in(); stop_insn = 1'b1; cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h02;
        tick(); idle(2);
        cur_req = "R5"; irq(8'h04, 4'h0); idle(1);
        cur_req = "R7"; stop_now(); idle(2);
        irq(8'h00, 4'h1); idle(1);

        // R8: enable writes in run and wait; address 3 ignored
        cur_req = "R8"; wr(2'd2, 8'h81); idle(1);
        wr(2'd3, 8'hFF); idle(1);
        wr(2'd0, 8'h00); stop_now(); wr(2'd2, 8'h7E); idle(2);
        irq(8'h00, 4'h4); idle(1);
        // R3: doze with mask captured from a mask write after address 3 write
        cur_req = "R3"; wr(2'd1, 8'hF0); wr(2'd0, 8'h01); stop_now(); idle(2);
        irq(8'h80, 4'h0); idle(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule